// File: doc/BRIEF.md
# Branch Condition Evaluator

This block decides whether a conditional jump instruction transfers control. It takes the 4-bit function code carried in the jump's opcode byte, together with the current zero, sign and overflow condition flags, and produces one taken bit. The decision depends only on those flags and the code; computing the jump target is left to the surrounding pipeline. In this instruction set the target is an absolute 32-bit address, not an offset from the program counter, so the fetch logic simply selects it when the taken bit is high.

The evaluator is purely combinational. Signed orderings are formed from the exclusive-OR of the sign and overflow flags, and the zero flag then extends "less" to "less-or-equal". Function codes outside the seven defined conditions yield not-taken and raise an invalid indication, which the decoder can turn into an illegal-instruction status.

Top module: `branch_cond_eval`

## Requirements
- R1: Code 0 (unconditional) gives taken_o = 1 for every flag combination.
- R2: Code 2 (less) gives taken_o = 1 exactly when sf_i differs from of_i.
- R3: Code 1 (less-or-equal) gives taken_o = 1 when sf_i differs from of_i or zf_i is 1.
- R4: Code 3 (equal) gives taken_o equal to zf_i.
- R5: Code 4 (not-equal) gives taken_o equal to the inverse of zf_i.
- R6: Code 5 (greater-or-equal) gives taken_o = 1 exactly when sf_i equals of_i.
- R7: Code 6 (greater) gives taken_o = 1 when sf_i equals of_i and zf_i is 0.
- R8: Codes 7 to 15 give taken_o = 0 and invalid_o = 1; codes 0 to 6 give invalid_o = 0.
- R9: Outputs depend only on the present inputs: a change of a flag alone, with the code held, updates taken_o without any clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| func_i | input | FUNC_W (4) | Jump function code |
| zf_i | input | 1 | Zero flag |
| sf_i | input | 1 | Sign flag |
| of_i | input | 1 | Overflow flag |
| taken_o | output | 1 | Jump is taken |
| invalid_o | output | 1 | Function code is undefined |

## Verification
Less-or-equal and greater are the two conditions where the signed comparison and the zero test act together in one evaluation. The bench provokes this by driving zf_i = 1 at the same time as sf_i differs from of_i, including combinations an adder would never produce, and judges the outcome against an independent model: less-or-equal must be taken and greater must not. Every code is swept over all eight flag combinations, and flag-only changes are checked between clock edges.

// File: rtl/bce_pkg.sv
package bce_pkg;
  localparam int COND_W = 4;

  typedef enum logic [COND_W-1:0] {
    COND_ALWAYS = 4'd0,
    COND_LE     = 4'd1,
    COND_LT     = 4'd2,
    COND_EQ     = 4'd3,
    COND_NE     = 4'd4,
    COND_GE     = 4'd5,
    COND_GT     = 4'd6
  } cond_e;

  localparam int NUM_VALID = 7;

  typedef struct packed {
    logic zf;
    logic sf;
    logic of;
  } flags_t;
endpackage

// File: rtl/bce_flag_cmp.sv
module bce_flag_cmp
  import bce_pkg::*;
(
  input  flags_t flags_i,
  output logic   lt_o,
  output logic   le_o
);
  // signed less: sign disagrees with overflow
  assign lt_o = flags_i.sf ^ flags_i.of;
  assign le_o = lt_o | flags_i.zf;
endmodule

// File: rtl/bce_cond_select.sv
module bce_cond_select
  import bce_pkg::*;
#(
  parameter int FUNC_W = COND_W
) (
  input  logic [FUNC_W-1:0] func_i,
  input  flags_t            flags_i,
  input  logic              lt_i,
  input  logic              le_i,
  output logic              taken_o,
  output logic              invalid_o
);
  localparam int NUM_CODES = 1 << FUNC_W;

  logic [NUM_CODES-1:0] hit;

  for (genvar g = 0; g < NUM_CODES; g++) begin : g_code
    if (g == int'(COND_ALWAYS)) begin : g_always
      assign hit[g] = 1'b1;
    end else if (g == int'(COND_LE)) begin : g_le
      assign hit[g] = le_i;
    end else if (g == int'(COND_LT)) begin : g_lt
      assign hit[g] = lt_i;
    end else if (g == int'(COND_EQ)) begin : g_eq
      assign hit[g] = flags_i.zf;
    end else if (g == int'(COND_NE)) begin : g_ne
      assign hit[g] = ~flags_i.zf;
    end else if (g == int'(COND_GE)) begin : g_ge
      assign hit[g] = ~lt_i;
    end else if (g == int'(COND_GT)) begin : g_gt
      assign hit[g] = ~le_i;
    end else begin : g_undef
      assign hit[g] = 1'b0;
    end
  end

  assign taken_o   = hit[func_i];
  assign invalid_o = (func_i >= FUNC_W'(NUM_VALID));
endmodule

// File: rtl/branch_cond_eval.sv
module branch_cond_eval
  import bce_pkg::*;
#(
  parameter int FUNC_W = COND_W
) (
  input  logic [FUNC_W-1:0] func_i,
  input  logic              zf_i,
  input  logic              sf_i,
  input  logic              of_i,
  output logic              taken_o,
  output logic              invalid_o
);
  flags_t flags;
  logic   lt, le;

  assign flags = '{zf: zf_i, sf: sf_i, of: of_i};

  bce_flag_cmp u_cmp (
    .flags_i (flags),
    .lt_o    (lt),
    .le_o    (le)
  );

  bce_cond_select #(.FUNC_W(FUNC_W)) u_sel (
    .func_i    (func_i),
    .flags_i   (flags),
    .lt_i      (lt),
    .le_i      (le),
    .taken_o   (taken_o),
    .invalid_o (invalid_o)
  );
endmodule

// File: rtl/branch_cond_eval_chk.sv
module branch_cond_eval_chk #(
  parameter int FUNC_W = 4
) (
  input logic [FUNC_W-1:0] func_i,
  input logic              zf_i,
  input logic              sf_i,
  input logic              of_i,
  input logic              taken_o,
  input logic              invalid_o
);
  always_comb begin
    if (func_i == FUNC_W'(0)) AST_UNCOND_TAKEN: assert (taken_o && !invalid_o); // R1
    if (func_i == FUNC_W'(2)) AST_LT_SIGNED: assert (taken_o == (sf_i != of_i)); // R2
    if (func_i == FUNC_W'(1) && zf_i) AST_LE_ON_ZERO: assert (taken_o); // R3
    if (func_i == FUNC_W'(3)) AST_EQ_ZERO: assert (taken_o == zf_i); // R4
    if (func_i == FUNC_W'(4)) AST_NE_ZERO: assert (taken_o != zf_i); // R5
    if (func_i == FUNC_W'(5)) AST_GE_SIGNED: assert (taken_o == (sf_i == of_i)); // R6
    if (func_i == FUNC_W'(6) && zf_i) AST_GT_NOT_ZERO: assert (!taken_o); // R7
    if (invalid_o) AST_INVALID_NOT_TAKEN: assert (!taken_o); // R8
    if (func_i < FUNC_W'(7)) AST_VALID_CODE: assert (!invalid_o); // R8
  end
endmodule

bind branch_cond_eval branch_cond_eval_chk #(.FUNC_W(FUNC_W)) u_chk (
  .func_i    (func_i),
  .zf_i      (zf_i),
  .sf_i      (sf_i),
  .of_i      (of_i),
  .taken_o   (taken_o),
  .invalid_o (invalid_o)
);

// File: tb/branch_cond_eval_tb_top.sv
module branch_cond_eval_tb_top;
  localparam int FUNC_W = 4;

  logic              clk;
  logic              rst_ni;
  logic [FUNC_W-1:0] func;
  logic              zf, sf, of;
  logic              taken, invalid;
  int                n_checks = 0;
  int                n_fail   = 0;
  bit                done     = 0;

  initial clk = 1'b0;
  always #2 clk = ~clk; // 250 MHz

  branch_cond_eval #(.FUNC_W(FUNC_W)) dut_i (
    .func_i    (func),
    .zf_i      (zf),
    .sf_i      (sf),
    .of_i      (of),
    .taken_o   (taken),
    .invalid_o (invalid)
  );

  function automatic bit exp_taken(int code, bit z, bit s, bit o);
    bit less = (s != o);
    case (code)
      0: return 1'b1;
      1: return less || z;
      2: return less;
      3: return z;
      4: return !z;
      5: return !less;
      6: return !less && !z;
      default: return 1'b0;
    endcase
  endfunction

  task automatic check(string req, string what, bit act, bit exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%0b expected=%0b", req, what, act, exp);
    end
  endtask

  task automatic apply(int code, int f);
    @(negedge clk);
    func = FUNC_W'(code);
    zf = f[2]; sf = f[1]; of = f[0];
    #1;
  endtask

  task automatic sweep_code(string req, int code);
    for (int f = 0; f < 8; f++) begin
      apply(code, f);
      check(req, $sformatf("code=%0d flags=%03b taken", code, f[2:0]), taken,
            exp_taken(code, f[2], f[1], f[0]));
      check(req, $sformatf("code=%0d invalid", code), invalid, code >= 7);
    end
  endtask

  task automatic t_reset_state;
    // no state: code 0 with clear flags is taken even while reset is held
    check("R1", "during reset taken", taken, 1'b1);
    check("R8", "during reset invalid", invalid, 1'b0);
  endtask

  task automatic t_uncond;  sweep_code("R1", 0); endtask
  task automatic t_less;    sweep_code("R2", 2); endtask
  task automatic t_less_eq; sweep_code("R3", 1); endtask
  task automatic t_equal;   sweep_code("R4", 3); endtask
  task automatic t_not_eq;  sweep_code("R5", 4); endtask
  task automatic t_ge;      sweep_code("R6", 5); endtask
  task automatic t_gt;      sweep_code("R7", 6); endtask

  task automatic t_invalid;
    for (int c = 7; c < 16; c++) sweep_code("R8", c);
  endtask

  task automatic t_overlap;
    // zero together with signed-less: le taken, gt not taken
    apply(1, 3'b110);
    check("R3", "zf&less le", taken, 1'b1);
    apply(6, 3'b101);
    check("R7", "zf&less gt", taken, 1'b0);
    apply(6, 3'b011);
    check("R7", "sf==of no zero gt", taken, 1'b1);
  endtask

  task automatic t_comb;
    apply(3, 3'b000);
    check("R9", "eq before", taken, 1'b0);
    @(posedge clk);
    #1;
    zf = 1'b1;
    #0.5;
    check("R9", "eq after flag change mid-cycle", taken, 1'b1);
    sf = 1'b1;
    func = FUNC_W'(2);
    #0.5;
    check("R9", "lt after code change mid-cycle", taken, 1'b1);
  endtask

  initial begin
    rst_ni = 1'b0;
    func = '0; zf = 1'b0; sf = 1'b0; of = 1'b0;
    repeat (2) @(posedge clk);
    #1;
    t_reset_state();
    rst_ni = 1'b1;
    t_uncond();
    t_less();
    t_less_eq();
    t_equal();
    t_not_eq();
    t_ge();
    t_gt();
    t_invalid();
    t_overlap();
    t_comb();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual=timeout expected=completion");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule